// File: doc/BRIEF.md
# Clock Reference Selector with Force Override

This block chooses which of eight candidate input clocks drives a timing loop. Each candidate carries a valid flag and a programmed priority value. In automatic operation the block picks the best available candidate, either sticking with its current choice (nonrevertive) or always moving to the best one (revertive). A 4-bit override code can pin the choice to one particular input. That input then ranks above every programmed priority.

The block also reports the state of the loop. Two fault flags describe the currently selected input. A short-term fault puts the loop into mini-holdover. A long-term fault puts it into full holdover. When the faults clear and the selected input is valid, the loop returns to locked. The selection is frozen while either fault flag is raised. While an override is active, the block never moves to any input other than the overridden one, even when that input is invalid.

All outputs are registered. A decision made from the inputs sampled at one rising edge shows on the outputs straight after that edge.

Top module: `ref_clk_selector`

## Requirements
- R1: While rst_ni is low, sel_idx_o is 0, ref_ok_o is 0 and loop_st_o is 2'b10 (full holdover). The state encoding is 2'b00 locked, 2'b01 mini-holdover, 2'b10 full holdover.
- R2: Slot i's priority is prio_i[4*i+3:4*i]. An input is a candidate when valid_i[i] is 1 and its priority is nonzero. The best candidate is the one with the smallest priority value. A tie goes to the lower slot index.
- R3: In nonrevertive mode (revert_i = 0) with no override, the current selection is kept while it is usable (ref_ok_o = 1, valid, nonzero priority). The block moves to the best candidate only when the current selection is not usable.
- R4: In revertive mode (revert_i = 1) with no override, the output is the best candidate one clock after the inputs are sampled.
- R5: Override code decoding: codes 1 to 6 select slots 0 to 5, code 8 selects slot 6 and code 9 selects slot 7. Codes 0, 7 and 10 to 15 mean automatic selection.
- R6: In revertive mode, a valid overridden slot is selected on the next clock, even when its priority is zero.
- R7: In nonrevertive mode, a valid overridden slot takes over only when the current selection is not usable.
- R8: While an override is active and the overridden slot is invalid, sel_idx_o and ref_ok_o do not change.
- R9: A short-term fault without a long-term fault gives mini-holdover on the next clock.
- R10: A long-term fault gives full holdover on the next clock, whatever the short-term flag is.
- R11: While either fault flag is high, sel_idx_o and ref_ok_o are held.
- R12: With no fault, ref_ok_o = 1 and the selected input valid, the next state is locked. With no fault otherwise, the next state is full holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 8 | Per-slot valid flag |
| prio_i | input | 32 | Per-slot 4-bit priority, slot i at bits 4*i+3:4*i, 0 = unavailable |
| revert_i | input | 1 | Revertive mode |
| force_i | input | 4 | Override code |
| short_flt_i | input | 1 | Short-term activity fault of the selected input |
| long_flt_i | input | 1 | Long-term activity fault of the selected input |
| sel_idx_o | output | 3 | Selected slot |
| ref_ok_o | output | 1 | A slot has been selected since reset |
| loop_st_o | output | 2 | Loop state |

## Verification
The properties take the fault flags as statements about whichever slot is selected at that moment. They place no constraint linking the fault flags to valid_i, so the stimulus drives all of these independently, including faults on a selection that is already invalid. All inputs are held steady across each rising edge. The bench changes them only one nanosecond after an edge, which gives every input exactly one sampled value per cycle, as the one-cycle properties expect. Override codes cover every value from 0 to 15, and priorities include zero and ties, so the decode and tie-break properties are exercised.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'b00,
    ST_MINI = 2'b01,
    ST_HOLD = 2'b10
  } loop_st_e;
endpackage

// File: rtl/ref_sel_force_dec.sv
module ref_sel_force_dec #(
  parameter int N_IN  = 8,
  parameter int IDX_W = 3
) (
  input  logic [3:0]       force_i,
  output logic             act_o,
  output logic [IDX_W-1:0] slot_o
);
  int idx;
  always_comb begin
    case (force_i)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: idx = int'(force_i) - 1;
      4'd8, 4'd9:                         idx = int'(force_i) - 2;
      default:                            idx = -1;
    endcase
    act_o  = (idx >= 0) && (idx < N_IN);
    slot_o = act_o ? IDX_W'(idx) : '0;
  end
endmodule

// File: rtl/ref_sel_prio_pick.sv
module ref_sel_prio_pick #(
  parameter int N_IN   = 8,
  parameter int PRIO_W = 4,
  parameter int IDX_W  = 3
) (
  input  logic [N_IN-1:0]        valid_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic                   found_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [PRIO_W-1:0] prio_a [N_IN];
  logic [N_IN-1:0]   cand;

  for (genvar g = 0; g < N_IN; g++) begin : g_slot
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
    assign cand[g]   = valid_i[g] && (prio_a[g] != '0);
  end

  logic [PRIO_W-1:0] best;
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    // strict compare keeps the lower index on ties
    for (int i = 0; i < N_IN; i++) begin
      if (cand[i] && (!found_o || prio_a[i] < best)) begin
        found_o = 1'b1;
        best    = prio_a[i];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ref_sel_loop_state.sv
module ref_sel_loop_state
  import ref_sel_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     short_flt_i,
  input  logic     long_flt_i,
  input  logic     ref_good_i,
  output loop_st_e st_o
);
  loop_st_e st_d;
  always_comb begin
    if (long_flt_i)       st_d = ST_HOLD;
    else if (short_flt_i) st_d = ST_MINI;
    else if (ref_good_i)  st_d = ST_LOCK;
    else                  st_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_o <= ST_HOLD;
    else         st_o <= st_d;
  end
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
  import ref_sel_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        valid_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic                   revert_i,
  input  logic [3:0]             force_i,
  input  logic                   short_flt_i,
  input  logic                   long_flt_i,
  output logic [IDX_W-1:0]       sel_idx_o,
  output logic                   ref_ok_o,
  output logic [1:0]             loop_st_o
);
  logic             f_act;
  logic [IDX_W-1:0] f_slot;
  logic             best_found;
  logic [IDX_W-1:0] best_idx;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             ok_q, ok_d;
  loop_st_e         st;

  ref_sel_force_dec #(.N_IN(N_IN), .IDX_W(IDX_W)) u_dec (
    .force_i (force_i),
    .act_o   (f_act),
    .slot_o  (f_slot)
  );

  ref_sel_prio_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .valid_i (valid_i),
    .prio_i  (prio_i),
    .found_o (best_found),
    .idx_o   (best_idx)
  );

  logic [PRIO_W-1:0] cur_prio;
  logic              cur_valid, cur_usable, fault;
  assign cur_prio   = prio_i[sel_q*PRIO_W +: PRIO_W];
  assign cur_valid  = valid_i[sel_q];
  assign cur_usable = ok_q && cur_valid && (cur_prio != '0);
  assign fault      = short_flt_i || long_flt_i;

  always_comb begin
    sel_d = sel_q;
    ok_d  = ok_q;
    if (!fault) begin
      if (f_act) begin
        // override: only the forced slot may ever be chosen
        if (valid_i[f_slot] && (revert_i || !cur_usable)) begin
          sel_d = f_slot;
          ok_d  = 1'b1;
        end
      end else if (best_found && (revert_i || !cur_usable)) begin
        sel_d = best_idx;
        ok_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ok_q  <= ok_d;
    end
  end

  ref_sel_loop_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .short_flt_i (short_flt_i),
    .long_flt_i  (long_flt_i),
    .ref_good_i  (ok_q && cur_valid),
    .st_o        (st)
  );

  assign sel_idx_o = sel_q;
  assign ref_ok_o  = ok_q;
  assign loop_st_o = st;
endmodule

// File: rtl/ref_clk_selector_chk.sv
module ref_clk_selector_chk #(
  parameter int N_IN   = 8,
  parameter int IDX_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_IN-1:0]  valid_i,
  input logic             revert_i,
  input logic [3:0]       force_i,
  input logic             short_flt_i,
  input logic             long_flt_i,
  input logic [IDX_W-1:0] sel_idx_o,
  input logic             ref_ok_o,
  input logic [1:0]       loop_st_o
);
  logic             f_act, f_vld;
  logic [IDX_W-1:0] f_slot;
  always_comb begin
    f_act  = 1'b0;
    f_slot = '0;
    case (force_i)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin f_act = 1'b1; f_slot = IDX_W'(force_i - 4'd1); end
      4'd8, 4'd9:                         begin f_act = 1'b1; f_slot = IDX_W'(force_i - 4'd2); end
      default: ;
    endcase
    f_vld = f_act && valid_i[f_slot];
  end

  a_r8_forced_invalid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_act && !f_vld) |=> ($stable(sel_idx_o) && $stable(ref_ok_o)));

  a_r6_revert_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (revert_i && f_vld && !short_flt_i && !long_flt_i) |=> (sel_idx_o == $past(f_slot) && ref_ok_o));

  a_r9_mini: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_flt_i && !long_flt_i) |=> (loop_st_o == 2'b01));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_flt_i |=> (loop_st_o == 2'b10));

  a_r11_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_flt_i || long_flt_i) |=> ($stable(sel_idx_o) && $stable(ref_ok_o)));

  a_r12_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!short_flt_i && !long_flt_i && ref_ok_o && valid_i[sel_idx_o]) |=> (loop_st_o == 2'b00));
endmodule

bind ref_clk_selector ref_clk_selector_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .revert_i    (revert_i),
  .force_i     (force_i),
  .short_flt_i (short_flt_i),
  .long_flt_i  (long_flt_i),
  .sel_idx_o   (sel_idx_o),
  .ref_ok_o    (ref_ok_o),
  .loop_st_o   (loop_st_o)
);

// File: tb/sim_ref_clk_selector.sv
`timescale 1ns/1ps
module sim_ref_clk_selector;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  valid = '0;
  logic [3:0]  prio [8];
  logic [31:0] prio_bus;
  logic        revert = 1'b0;
  logic [3:0]  force_c = '0;
  logic        sflt = 1'b0, lflt = 1'b0;
  logic [2:0]  sel;
  logic        ok;
  logic [1:0]  st;

  int checks = 0, errors = 0;
  int m_sel = 0, m_ok = 0, m_st = 2;
  string tag = "R1";

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) prio_bus[i*4 +: 4] = prio[i];

  ref_clk_selector u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .prio_i(prio_bus),
    .revert_i(revert), .force_i(force_c), .short_flt_i(sflt), .long_flt_i(lflt),
    .sel_idx_o(sel), .ref_ok_o(ok), .loop_st_o(st)
  );

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic int fslot(int c);
    if (c >= 1 && c <= 6) return c - 1;
    if (c == 8 || c == 9) return c - 2;
    return -1;
  endfunction

  task automatic model_step();
    int fs, best, bp, nsel, nok, nst;
    bit usable;
    fs = fslot(int'(force_c));
    if (lflt) nst = 2;
    else if (sflt) nst = 1;
    else if (m_ok == 1 && valid[m_sel]) nst = 0;
    else nst = 2;
    nsel = m_sel; nok = m_ok;
    if (!sflt && !lflt) begin
      usable = (m_ok == 1) && valid[m_sel] && (prio[m_sel] != 0);
      if (fs >= 0) begin
        if (valid[fs] && (revert || !usable)) begin nsel = fs; nok = 1; end
      end else begin
        best = -1; bp = 16;
        for (int i = 0; i < 8; i++)
          if (valid[i] && prio[i] != 0 && int'(prio[i]) < bp) begin bp = int'(prio[i]); best = i; end
        if (best >= 0 && (revert || !usable)) begin nsel = best; nok = 1; end
      end
    end
    m_sel = nsel; m_ok = nok; m_st = nst;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk({tag, " model sel"}, int'(sel), m_sel);
    chk({tag, " model ok"}, int'(ok), m_ok);
    chk({tag, " model state"}, int'(st), m_st);
  endtask

  task automatic finish_all();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_all();
  end

  initial begin
    for (int i = 0; i < 8; i++) prio[i] = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset sel", int'(sel), 0);
    chk("R1 reset ok", int'(ok), 0);
    chk("R1 reset state", int'(st), 2);
    rst_ni = 1'b1;

    // R2: best candidate, zero priority excluded
    tag = "R2";
    prio[0] = 5; prio[1] = 3; prio[2] = 3; prio[3] = 0;
    prio[4] = 7; prio[5] = 2; prio[6] = 9; prio[7] = 1;
    valid = 8'b0011_1111;
    tick();
    chk("R2 lowest prio picked", int'(sel), 5);
    tick();
    chk("R12 locked after select", int'(st), 0);

    // R3: nonrevertive stays, moves on loss
    tag = "R3";
    valid = 8'b1011_1111;
    tick(); tick();
    chk("R3 nonrevertive keeps", int'(sel), 5);
    valid = 8'b1001_1111;
    tick();
    chk("R3 moves on loss", int'(sel), 7);
    chk("R12 hold on invalid ref", int'(st), 2);
    tick();
    chk("R12 relock", int'(st), 0);

    // R4: revertive, tie goes to lower index
    tag = "R4";
    revert = 1'b1; prio[0] = 1; valid = 8'hFF;
    tick();
    chk("R4 revert tie lower idx", int'(sel), 0);

    // R5: unused codes act as automatic
    tag = "R5";
    for (int c = 0; c < 16; c++) begin
      if (fslot(c) >= 0) continue;
      force_c = 4'(c);
      tick();
      chk("R5 unused code automatic", int'(sel), 0);
    end

    // R6: revertive force takes over at once, even priority 0
    tag = "R6";
    force_c = 4'd9; tick();
    chk("R6 code9 slot7", int'(sel), 7);
    force_c = 4'd8; tick();
    chk("R6 code8 slot6", int'(sel), 6);
    force_c = 4'd4; tick();
    chk("R6 prio0 forced", int'(sel), 3);

    // R8: forced slot invalid, no switch
    tag = "R8";
    valid[3] = 1'b0;
    repeat (3) tick();
    chk("R8 hold on forced invalid", int'(sel), 3);
    force_c = 4'd2; valid[1] = 1'b0;
    repeat (2) tick();
    chk("R8 no switch to others", int'(sel), 3);

    // R7: nonrevertive force waits for loss
    tag = "R7";
    revert = 1'b0; force_c = 4'd0; valid = 8'hFF;
    tick();
    chk("R3 unusable ref replaced", int'(sel), 0);
    force_c = 4'd5;
    repeat (2) tick();
    chk("R7 force waits", int'(sel), 0);
    valid[0] = 1'b0;
    tick();
    chk("R7 force takes over", int'(sel), 4);

    // R9 R10 R11: faults
    tag = "R11";
    revert = 1'b1; force_c = 4'd0; valid = 8'hFF;
    sflt = 1'b1;
    tick();
    chk("R9 mini holdover", int'(st), 1);
    chk("R11 frozen short", int'(sel), 4);
    lflt = 1'b1;
    tick();
    chk("R10 full holdover", int'(st), 2);
    chk("R11 frozen long", int'(sel), 4);
    sflt = 1'b0; lflt = 1'b0;
    tick();
    chk("R12 lock after clear", int'(st), 0);
    chk("R4 revert after clear", int'(sel), 0);

    // random mix against model
    tag = "R2 R4 R12";
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 7) == 0) valid = 8'($urandom);
      if ($urandom_range(0, 15) == 0) prio[$urandom_range(0, 7)] = 4'($urandom);
      if ($urandom_range(0, 31) == 0) revert = ~revert;
      if ($urandom_range(0, 15) == 0) force_c = 4'($urandom);
      sflt = ($urandom_range(0, 9) == 0);
      lflt = ($urandom_range(0, 19) == 0);
      tick();
    end
    finish_all();
  end
endmodule